// File: doc/BRIEF.md
# Three-Dimensional DMA Transfer Sequencer

This block walks a DMA parameter set that describes a block of frames, each frame made of arrays, each array made of bytes. Every synchronization event it receives becomes one transfer request (TR) for a downstream data mover. Each TR carries a source address, a destination address, an array byte count, an array count and the array strides. After issuing a TR the sequencer advances its live copy of the set, so addresses and counts are ready for the next event. Two event granularities are supported: one array per event, or one whole frame per event.

Software programs parameter sets through a simple word-write port. Set 0 is the channel's own set. A write to set 0 lands both in the live registers and in the backing RAM. Writes to other sets land in the RAM only, where they wait to be linked in. When the live set is used up, the sequencer either copies a linked set from the RAM into the live registers or parks on an empty set. Events that arrive while the set is empty, or while the one-deep event latch is already full, are counted as missed.

Top module: `dma_tr_sequencer`

## Requirements
- R1: A set is eight 32-bit words, indexed by word number. 0 is options, with bit 2 = frame-per-event and bit 3 = static. 1 is the source address. 2 holds array bytes in [15:0] and arrays per frame in [31:16]. 3 is the destination address. 4 holds the source array stride in [15:0] and the destination array stride in [31:16]. 5 holds the link in [15:0] and the array-count reload in [31:16]. 6 holds the source frame stride in [15:0] and the destination frame stride in [31:16]. 7 holds the frame count in [15:0]. Strides are signed 16-bit. After reset the live set is empty: all counts are zero and the link is 0xFFFF. No TR is pending, and the miss count and error flag are zero.
- R2: In array-per-event mode each TR has tr_bcnt = 1, tr_acnt = the array byte count and zero strides. Within a frame, each next array starts at the previous addresses plus the array strides.
- R3: In array-per-event mode, after the last array of a frame the addresses advance by the frame strides, measured from that last array. The arrays-per-frame count is then restored from the reload field. The set completes after the last array of the last frame.
- R4: In frame-per-event mode each TR covers a whole frame, with tr_bcnt = arrays per frame and the array strides. Each next frame starts at the previous frame's first-array addresses plus the frame strides. The set completes after frame-count TRs.
- R5: tr_valid stays high and all TR fields stay unchanged until tr_ready is seen high. The TR is accepted in the cycle where both are high.
- R6: In the cycle after a TR is accepted, exactly one of set_done (the final TR of the set) or set_step (any other TR) is high, for one cycle.
- R7: When the final TR of a non-static set is accepted and its link is not 0xFFFF, set (link >> 5) mod NUM_SETS is copied from the RAM into the live set. Later events are served from the copied set.
- R8: When the final TR of a non-static set is accepted and its link is 0xFFFF, the live set becomes empty.
- R9: With the static bit set, the live set is never advanced or linked. Every event yields the same TR, and every TR is final.
- R10: An event that arrives while a TR is pending or a link copy runs is held in a one-deep latch and served afterwards. An event that arrives while the latch is already full is dropped and counted as missed.
- R11: An event served while the live set is empty (any count zero) issues no TR. It increments the saturating miss_cnt and sets miss_err, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Parameter word write strobe |
| cfg_set | input | SET_W | Set index of the write |
| cfg_word | input | 3 | Word index within the set |
| cfg_wdata | input | 32 | Write data |
| evt | input | 1 | Synchronization event, one per cycle high |
| tr_valid | output | 1 | TR pending |
| tr_ready | input | 1 | Data mover accepts the TR |
| tr_src | output | 32 | TR source address |
| tr_dst | output | 32 | TR destination address |
| tr_acnt | output | 16 | Bytes per array |
| tr_bcnt | output | 16 | Arrays in this TR |
| tr_sbidx | output | 16 | Source array stride for this TR |
| tr_dbidx | output | 16 | Destination array stride for this TR |
| set_done | output | 1 | Final TR of the set accepted |
| set_step | output | 1 | Non-final TR accepted |
| miss_err | output | 1 | Sticky missed-event flag |
| miss_cnt | output | MISS_W | Saturating missed-event count |

## Verification
The hardest state to reach is the one where the event latch is full while a TR is stalled. Only a third event arriving during that stall shows the drop. The stimulus therefore holds tr_ready low, fires three events, and then releases the stall. A scoreboard checks that the latched event is then served from the advanced set. A second hard case is a link that points back to set 0, so the channel reloads its own original program from the RAM. A ping-pong pair of sets linked to each other covers this, and it shows that the live updates never overwrite the stored copy.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  localparam int WORD_W = 32;

  // word indices inside one parameter set
  localparam int W_OPT  = 0;
  localparam int W_SRC  = 1;
  localparam int W_CNT  = 2;
  localparam int W_DST  = 3;
  localparam int W_BIDX = 4;
  localparam int W_LINK = 5;
  localparam int W_CIDX = 6;
  localparam int W_CCNT = 7;

  localparam int OPT_AB_BIT     = 2;
  localparam int OPT_STATIC_BIT = 3;
  localparam int LINK_SHIFT     = 5;
  localparam logic [15:0] NO_LINK = 16'hFFFF;

  typedef logic [7:0][WORD_W-1:0] pset_t;

  localparam pset_t EMPTY_SET = {32'h0, 32'h0, 32'h0000_FFFF, 32'h0,
                                 32'h0, 32'h0, 32'h0, 32'h0};

  typedef struct packed {
    logic [31:0] src;
    logic [31:0] dst;
    logic [15:0] acnt;
    logic [15:0] bcnt;
    logic [15:0] sbidx;
    logic [15:0] dbidx;
  } tr_t;

  typedef enum logic [1:0] {ST_IDLE, ST_TR, ST_LINK} seq_st_t;
endpackage

// File: rtl/dma_seq_ram.sv
module dma_seq_ram #(
  parameter int AW = 7,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/dma_seq_step.sv
module dma_seq_step
  import dma_seq_pkg::*;
(
  input  pset_t live,
  output tr_t   tr,
  output pset_t nxt,
  output logic  is_final
);
  logic        ab, stat;
  logic [15:0] acnt, bcnt, ccnt, rld;
  logic [31:0] sb, db, sc, dc;
  logic        unused_bits;

  assign ab   = live[W_OPT][OPT_AB_BIT];
  assign stat = live[W_OPT][OPT_STATIC_BIT];
  assign acnt = live[W_CNT][15:0];
  assign bcnt = live[W_CNT][31:16];
  assign ccnt = live[W_CCNT][15:0];
  assign rld  = live[W_LINK][31:16];
  assign sb   = {{16{live[W_BIDX][15]}}, live[W_BIDX][15:0]};
  assign db   = {{16{live[W_BIDX][31]}}, live[W_BIDX][31:16]};
  assign sc   = {{16{live[W_CIDX][15]}}, live[W_CIDX][15:0]};
  assign dc   = {{16{live[W_CIDX][31]}}, live[W_CIDX][31:16]};

  assign unused_bits = ^{live[W_OPT][31:4], live[W_OPT][1:0],
                         live[W_CCNT][31:16], live[W_LINK][15:0]};

  always_comb begin
    tr.src   = live[W_SRC];
    tr.dst   = live[W_DST];
    tr.acnt  = acnt;
    tr.bcnt  = ab ? bcnt : 16'd1;
    tr.sbidx = ab ? live[W_BIDX][15:0]  : 16'd0;
    tr.dbidx = ab ? live[W_BIDX][31:16] : 16'd0;

    if (stat)    is_final = 1'b1;
    else if (ab) is_final = (ccnt == 16'd1);
    else         is_final = (bcnt == 16'd1) && (ccnt == 16'd1);

    nxt = live;
    if (ab) begin
      nxt[W_SRC]         = live[W_SRC] + sc;
      nxt[W_DST]         = live[W_DST] + dc;
      nxt[W_CCNT][15:0]  = ccnt - 16'd1;
    end else if (bcnt > 16'd1) begin
      nxt[W_SRC]         = live[W_SRC] + sb;
      nxt[W_DST]         = live[W_DST] + db;
      nxt[W_CNT][31:16]  = bcnt - 16'd1;
    end else begin
      nxt[W_SRC]         = live[W_SRC] + sc;
      nxt[W_DST]         = live[W_DST] + dc;
      nxt[W_CNT][31:16]  = rld;
      nxt[W_CCNT][15:0]  = ccnt - 16'd1;
    end
  end
endmodule

// File: rtl/dma_seq_link.sv
module dma_seq_link #(
  parameter int SET_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [SET_W-1:0] set_idx,
  output logic [SET_W+2:0] raddr,
  output logic             wr_en,
  output logic [2:0]       wr_idx,
  output logic             last
);
  logic             issuing;
  logic [2:0]       idx;
  logic [SET_W-1:0] set_q;

  assign raddr = {set_q, idx};
  assign last  = wr_en && (wr_idx == 3'd7);

  always_ff @(posedge clk) begin
    if (rst) begin
      issuing <= 1'b0;
      idx     <= '0;
      set_q   <= '0;
      wr_en   <= 1'b0;
      wr_idx  <= '0;
    end else begin
      wr_en  <= issuing;
      wr_idx <= idx;
      if (start) begin
        issuing <= 1'b1;
        idx     <= '0;
        set_q   <= set_idx;
      end else if (issuing) begin
        idx <= idx + 3'd1;
        if (idx == 3'd7) issuing <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dma_tr_sequencer.sv
module dma_tr_sequencer
  import dma_seq_pkg::*;
#(
  parameter int NUM_SETS = 16,
  parameter int MISS_W   = 8,
  localparam int SET_W   = $clog2(NUM_SETS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [SET_W-1:0]  cfg_set,
  input  logic [2:0]        cfg_word,
  input  logic [31:0]       cfg_wdata,
  input  logic              evt,
  output logic              tr_valid,
  input  logic              tr_ready,
  output logic [31:0]       tr_src,
  output logic [31:0]       tr_dst,
  output logic [15:0]       tr_acnt,
  output logic [15:0]       tr_bcnt,
  output logic [15:0]       tr_sbidx,
  output logic [15:0]       tr_dbidx,
  output logic              set_done,
  output logic              set_step,
  output logic              miss_err,
  output logic [MISS_W-1:0] miss_cnt
);
  localparam int RAM_AW = SET_W + 3;

  pset_t             live_w, step_nxt;
  tr_t               step_tr, tr_q;
  logic              step_final;
  seq_st_t           st;
  logic              pend, final_q, static_q;
  logic [31:0]       ram_rdata;
  logic [RAM_AW-1:0] ram_raddr;
  logic              link_wr, link_last;
  logic [2:0]        link_idx;
  logic [15:0]       link_f;
  logic              exhausted, idle, svc, issue, miss, accept, do_link, do_null;

  dma_seq_step u_step (
    .live(live_w), .tr(step_tr), .nxt(step_nxt), .is_final(step_final)
  );

  dma_seq_ram #(.AW(RAM_AW), .DW(WORD_W)) u_ram (
    .clk(clk), .we(cfg_we), .waddr({cfg_set, cfg_word}), .wdata(cfg_wdata),
    .raddr(ram_raddr), .rdata(ram_rdata)
  );

  dma_seq_link #(.SET_W(SET_W)) u_link (
    .clk(clk), .rst(rst), .start(do_link),
    .set_idx(link_f[LINK_SHIFT +: SET_W]),
    .raddr(ram_raddr), .wr_en(link_wr), .wr_idx(link_idx), .last(link_last)
  );

  assign link_f    = live_w[W_LINK][15:0];
  assign exhausted = (live_w[W_CNT][15:0] == 16'd0) || (live_w[W_CNT][31:16] == 16'd0) ||
                     (live_w[W_CCNT][15:0] == 16'd0);
  assign idle      = (st == ST_IDLE);
  assign svc       = idle && (pend || evt);
  assign issue     = svc && !exhausted;
  assign miss      = (svc && exhausted) || (!idle && evt && pend);
  assign accept    = (st == ST_TR) && tr_ready;
  assign do_link   = accept && final_q && !static_q && (link_f != NO_LINK);
  assign do_null   = accept && final_q && !static_q && (link_f == NO_LINK);

  assign tr_src   = tr_q.src;
  assign tr_dst   = tr_q.dst;
  assign tr_acnt  = tr_q.acnt;
  assign tr_bcnt  = tr_q.bcnt;
  assign tr_sbidx = tr_q.sbidx;
  assign tr_dbidx = tr_q.dbidx;

  // control, TR register, flags and miss accounting
  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      pend     <= 1'b0;
      tr_valid <= 1'b0;
      tr_q     <= '0;
      final_q  <= 1'b0;
      static_q <= 1'b0;
      set_done <= 1'b0;
      set_step <= 1'b0;
      miss_err <= 1'b0;
      miss_cnt <= '0;
    end else begin
      set_done <= 1'b0;
      set_step <= 1'b0;
      pend     <= idle ? (pend && evt) : (pend || evt);
      if (miss) begin
        miss_err <= 1'b1;
        if (miss_cnt != {MISS_W{1'b1}}) miss_cnt <= miss_cnt + 1'b1;
      end
      case (st)
        ST_IDLE: begin
          if (issue) begin
            tr_q     <= step_tr;
            tr_valid <= 1'b1;
            final_q  <= step_final;
            static_q <= live_w[W_OPT][OPT_STATIC_BIT];
            st       <= ST_TR;
          end
        end
        ST_TR: begin
          if (tr_ready) begin
            tr_valid <= 1'b0;
            set_done <= final_q;
            set_step <= !final_q;
            st       <= do_link ? ST_LINK : ST_IDLE;
          end
        end
        ST_LINK: begin
          if (link_last) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // live parameter set
  always_ff @(posedge clk) begin
    if (rst) begin
      live_w <= EMPTY_SET;
    end else begin
      if (cfg_we && (cfg_set == '0)) live_w[cfg_word] <= cfg_wdata;
      if (issue && !live_w[W_OPT][OPT_STATIC_BIT] && !step_final) live_w <= step_nxt;
      if (do_null) live_w <= EMPTY_SET;
      if (link_wr) live_w[link_idx] <= ram_rdata;
    end
  end
endmodule

// File: rtl/dma_tr_sequencer_chk.sv
module dma_tr_sequencer_chk #(
  parameter int MISS_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              tr_valid,
  input logic              tr_ready,
  input logic [31:0]       tr_src,
  input logic [31:0]       tr_dst,
  input logic [15:0]       tr_acnt,
  input logic [15:0]       tr_bcnt,
  input logic              set_done,
  input logic              set_step,
  input logic              miss_err,
  input logic [MISS_W-1:0] miss_cnt
);
  p_tr_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (tr_valid && !tr_ready) |=> (tr_valid && $stable(tr_src) && $stable(tr_dst) &&
                                 $stable(tr_acnt) && $stable(tr_bcnt)));

  p_flag_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(set_done && set_step));

  p_flag_cause_r6: assert property (@(posedge clk) disable iff (rst)
    (set_done || set_step) |-> $past(tr_valid && tr_ready));

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    set_done |=> !set_done);

  p_no_empty_tr_r11: assert property (@(posedge clk) disable iff (rst)
    tr_valid |-> (tr_acnt != 16'd0 && tr_bcnt != 16'd0));

  p_err_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    miss_err |=> miss_err);

  p_miss_step_r11: assert property (@(posedge clk) disable iff (rst)
    (miss_cnt != $past(miss_cnt)) |-> (miss_cnt == $past(miss_cnt) + 1'b1));

  p_miss_err_r10: assert property (@(posedge clk) disable iff (rst)
    (miss_cnt != '0) |-> miss_err);
endmodule

bind dma_tr_sequencer dma_tr_sequencer_chk #(.MISS_W(MISS_W)) u_chk (.*);

// File: tb/dma_tr_sequencer_tb_top.sv
`timescale 1ns/1ps
module dma_tr_sequencer_tb_top;
  localparam int NUM_SETS = 16;
  localparam int MISS_W   = 8;
  localparam int SET_W    = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cfg_we = 1'b0;
  logic [SET_W-1:0]  cfg_set = '0;
  logic [2:0]        cfg_word = '0;
  logic [31:0]       cfg_wdata = '0;
  logic              evt = 1'b0;
  logic              tr_ready = 1'b1;
  logic              tr_valid, set_done, set_step, miss_err;
  logic [31:0]       tr_src, tr_dst;
  logic [15:0]       tr_acnt, tr_bcnt, tr_sbidx, tr_dbidx;
  logic [MISS_W-1:0] miss_cnt;

  always #2 clk = ~clk;

  dma_tr_sequencer #(.NUM_SETS(NUM_SETS), .MISS_W(MISS_W)) dut_i (.*);

  typedef struct {
    logic [31:0] src, dst;
    logic [15:0] acnt, bcnt, sbidx, dbidx;
    bit          fin;
    string       req;
  } exp_t;

  exp_t        q[$];
  logic [31:0] m_live [8];
  logic [31:0] m_ram  [NUM_SETS*8];
  int          exp_miss = 0;
  bit          exp_err  = 0;
  int          n_checks = 0;
  int          n_errs   = 0;
  bit          flag_due = 0;
  bit          flag_fin = 0;
  string       flag_req;

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] sx(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  task automatic model_empty();
    for (int i = 0; i < 8; i++) m_live[i] = 32'h0;
    m_live[5] = 32'h0000_FFFF;
  endtask

  // R1..R4, R7..R9, R11 reference behaviour, derived from the requirement text
  task automatic model_event(input string req);
    exp_t        e;
    logic        ab, st;
    logic [15:0] acnt, bcnt, ccnt, lnk;
    int          ls;
    ab = m_live[0][2]; st = m_live[0][3];
    acnt = m_live[2][15:0]; bcnt = m_live[2][31:16]; ccnt = m_live[7][15:0];
    lnk = m_live[5][15:0];
    if (acnt == 0 || bcnt == 0 || ccnt == 0) begin
      exp_miss++; exp_err = 1;
      return;
    end
    e.src = m_live[1]; e.dst = m_live[3]; e.acnt = acnt;
    e.bcnt  = ab ? bcnt : 16'd1;
    e.sbidx = ab ? m_live[4][15:0]  : 16'd0;
    e.dbidx = ab ? m_live[4][31:16] : 16'd0;
    e.fin = st ? 1'b1 : (ab ? (ccnt == 1) : (bcnt == 1 && ccnt == 1));
    e.req = req;
    q.push_back(e);
    if (st) return;
    if (e.fin) begin
      if (lnk == 16'hFFFF) model_empty();
      else begin
        ls = int'(lnk >> 5) % NUM_SETS;
        for (int i = 0; i < 8; i++) m_live[i] = m_ram[ls*8+i];
      end
    end else if (ab || bcnt == 1) begin
      m_live[1] = m_live[1] + sx(m_live[6][15:0]);
      m_live[3] = m_live[3] + sx(m_live[6][31:16]);
      if (!ab) m_live[2][31:16] = m_live[5][31:16];
      m_live[7][15:0] = ccnt - 16'd1;
    end else begin
      m_live[1] = m_live[1] + sx(m_live[4][15:0]);
      m_live[3] = m_live[3] + sx(m_live[4][31:16]);
      m_live[2][31:16] = bcnt - 16'd1;
    end
  endtask

  task automatic cfg_write(input int s, input int w, input logic [31:0] d);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_set = SET_W'(s); cfg_word = 3'(w); cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
    m_ram[s*8+w] = d;
    if (s == 0) m_live[w] = d;
  endtask

  task automatic write_set(input int s, input logic [31:0] opt, src, dst,
                           input logic [15:0] acnt, bcnt, sb, db, lnk, rld, sc, dc, ccnt);
    cfg_write(s, 0, opt);
    cfg_write(s, 1, src);
    cfg_write(s, 2, {bcnt, acnt});
    cfg_write(s, 3, dst);
    cfg_write(s, 4, {db, sb});
    cfg_write(s, 5, {rld, lnk});
    cfg_write(s, 6, {dc, sc});
    cfg_write(s, 7, {16'h0, ccnt});
  endtask

  task automatic pulse_evt(input string req);
    model_event(req);
    @(posedge clk); #1 evt = 1'b1;
    @(posedge clk); #1 evt = 1'b0;
  endtask

  task automatic pulse_evt_dropped();
    exp_miss++; exp_err = 1;
    @(posedge clk); #1 evt = 1'b1;
    @(posedge clk); #1 evt = 1'b0;
  endtask

  task automatic settle();
    repeat (14) @(posedge clk);
  endtask

  task automatic do_reset();
    @(posedge clk); #1 rst = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    model_empty();
    exp_miss = 0; exp_err = 0;
    q.delete();
  endtask

  task automatic chk_miss(input string req);
    @(negedge clk);
    chk(req, miss_cnt, MISS_W'(exp_miss));
    chk(req, miss_err, exp_err);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (flag_due) begin
        chk({flag_req, " R6 done"}, set_done, flag_fin);
        chk({flag_req, " R6 step"}, set_step, !flag_fin);
        flag_due = 0;
      end else if (set_done || set_step) begin
        chk("R6 unsolicited flag", {set_done, set_step}, 2'b00);
      end
      if (tr_valid && tr_ready) begin
        if (q.size() == 0) begin
          chk("R5 unexpected TR", tr_src, 32'hDEAD_BEEF);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk({e.req, " TR"}, {tr_src, tr_dst, tr_acnt, tr_bcnt, tr_sbidx, tr_dbidx},
              {e.src, e.dst, e.acnt, e.bcnt, e.sbidx, e.dbidx});
          flag_due = 1; flag_fin = e.fin; flag_req = e.req;
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    n_errs++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    chk("R1 reset valid", tr_valid, 1'b0);
    chk("R1 reset flags", {set_done, set_step}, 2'b00);
    chk("R1 reset miss", miss_cnt, '0);
    chk("R1 reset err", miss_err, 1'b0);

    // R11: event on the empty set after reset
    pulse_evt("R11");
    settle();
    chk_miss("R11 empty set");

    do_reset();
    chk_miss("R1 miss cleared by reset");

    // R2, R3, R8: array-per-event with reload differing from the initial count
    write_set(0, 32'h0, 32'h1000, 32'h8000, 16'd4, 16'd3, 16'd16, 16'd32,
              16'hFFFF, 16'd2, 16'd100, 16'hFFF8, 16'd2);
    pulse_evt("R2"); settle();
    pulse_evt("R2"); settle();
    pulse_evt("R3"); settle();
    pulse_evt("R3"); settle();
    pulse_evt("R3"); settle();
    pulse_evt("R8"); settle();
    chk_miss("R8 empty after unlinked set");

    // R4, R7: frame-per-event set linked to a small array-per-event set
    write_set(3, 32'h0, 32'h4000, 32'h5000, 16'd2, 16'd1, 16'd0, 16'd0,
              16'hFFFF, 16'd0, 16'd0, 16'd0, 16'd1);
    write_set(0, 32'h4, 32'h2000, 32'h3000, 16'd8, 16'd4, 16'd8, 16'd16,
              16'h0060, 16'd0, 16'd64, 16'd128, 16'd3);
    pulse_evt("R4"); settle();
    pulse_evt("R4"); settle();
    pulse_evt("R4"); settle();
    pulse_evt("R7"); settle();
    pulse_evt("R8"); settle();
    chk_miss("R8 linked set ended");

    // R9: static set ignores its link and never advances
    write_set(0, 32'hC, 32'h6000, 32'h7000, 16'd4, 16'd2, 16'd4, 16'd4,
              16'h0060, 16'd0, 16'd32, 16'd32, 16'd1);
    pulse_evt("R9"); settle();
    pulse_evt("R9"); settle();
    pulse_evt("R9"); settle();
    chk_miss("R9 no misses");

    // R5, R10: stall the mover, latch one event, drop the next
    write_set(0, 32'h0, 32'h100, 32'h200, 16'd1, 16'd8, 16'd1, 16'd1,
              16'hFFFF, 16'd8, 16'd0, 16'd0, 16'd1);
    @(posedge clk); #1 tr_ready = 1'b0;
    pulse_evt("R5");
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R5 held valid", tr_valid, 1'b1);
    chk("R5 held src", tr_src, 32'h100);
    pulse_evt("R10");
    pulse_evt_dropped();
    @(negedge clk);
    chk("R5 still held", tr_src, 32'h100);
    @(posedge clk); #1 tr_ready = 1'b1;
    settle();
    chk_miss("R10 overflow counted");

    // R7: ping-pong between set 1 and set 0
    write_set(1, 32'h0, 32'hA0, 32'hB0, 16'd1, 16'd1, 16'd0, 16'd0,
              16'h0000, 16'd0, 16'd0, 16'd0, 16'd1);
    write_set(0, 32'h0, 32'hC0, 32'hD0, 16'd1, 16'd1, 16'd0, 16'd0,
              16'h0020, 16'd0, 16'd0, 16'd0, 16'd1);
    pulse_evt("R7"); settle();
    pulse_evt("R7"); settle();
    pulse_evt("R7"); settle();
    pulse_evt("R7"); settle();
    chk_miss("R7 no misses");

    chk("R5 scoreboard drained", 128'(q.size()), 128'd0);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end
endmodule